// File: doc/BRIEF.md
# Host Boot-Byte Pacer

This block sits on the host side of a slave processor that has no host port. It boots that processor by feeding it code one byte at a time through the slave's external memory data lines. The slave's bus-request input paces the transfer. The pacer holds the slave in reset and sets a bus-request flop, then lets the slave run. For every byte it drives the value onto an 8-bit bus and clears the flop. That clear lets the slave perform exactly one boot read. The slave's active-low boot-strobe presets the flop again asynchronously, which freezes the slave until the next byte.

Boot bytes arrive on a valid/ready stream with a last flag. After the last byte has been read, the pacer clears the flop one final time so the slave runs freely. It releases the data bus and raises a done level, which holds until the next start request. The wait after each release is a parameter. The pacer can optionally require that the slave reports bus grant before it offers the next byte.

Top module: `boot_pacer`

## Requirements
- R1: While rst_n is low and on leaving it, slave_reset_n is 0, br_n is 0, data_oe is 0, data_out is 0, in_ready is 0 and boot_done is 0.
- R2: A boot_start seen while idle or done holds slave_reset_n low and sets the bus-request flop. slave_reset_n rises only while br_n is already 0.
- R3: in_ready is high only while the slave is out of reset, no boot has completed and br_n is 0. Accepted bytes appear on data_out with data_oe high, and the slave reads them in stream order.
- R4: Each accepted byte produces exactly one rise of br_n, lasting one release. A low level on bms_n forces br_n to 0 at once, without waiting for a clock edge.
- R5: After br_n rises for a byte, data_out stays unchanged for at least WAIT_CYC clock cycles.
- R6: With GRANT_CHECK = 1, no further byte is offered until the slave has pulsed bms_n and bg_n has been seen low after the release. Every byte accepted so far has then been read.
- R7: After the byte flagged last has been read and its wait has expired, boot_done is 1, slave_reset_n is 1, br_n is 1, data_oe is 0 and data_out is 0.
- R8: A boot_start while a boot is in progress with slave_reset_n high has no effect. The slave is not reset again, and the boot's byte order is unchanged.
- R9: boot_done stays 1 until the next boot_start. That start drives slave_reset_n low and clears boot_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, also the slave cycle reference for waits |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_start | input | 1 | Request to begin a boot, honoured only when idle or done |
| in_data | input | 8 | Boot byte of the incoming stream |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | The current byte is the final boot byte |
| in_ready | output | 1 | Pacer accepts a byte this cycle |
| slave_reset_n | output | 1 | Active-low reset to the slave |
| br_n | output | 1 | Active-low bus request to the slave |
| bms_n | input | 1 | Slave's active-low boot-strobe, asynchronous |
| bg_n | input | 1 | Slave's active-low bus grant, asynchronous |
| data_out | output | 8 | Byte driven to the slave data lines |
| data_oe | output | 1 | Output enable of the data driver, 0 means high impedance |
| boot_done | output | 1 | Level, high after a completed boot until the next start |

## Verification
The bound checker watches several properties on every cycle. It checks that the slave leaves reset only with bus request asserted, that a low strobe always shows as asserted bus request, and that each byte release is a single cycle. It also checks that data stays frozen for the wait window after a release, that a start during a boot never re-resets the slave, and that done excludes the driver and holds until a start. Only the bench scenarios can show the rest. Those cover the byte order as seen by a modelled slave, one read per byte, and the stall behind a slow slave under the grant gate. They also cover a start ignored mid-boot, a one-byte boot, and an abort by reset partway through a boot.

// File: rtl/boot_pacer_pkg.sv
package boot_pacer_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_GET,
    ST_SETUP,
    ST_REL,
    ST_HOLD,
    ST_GRANT,
    ST_FIN,
    ST_DONE
  } pace_state_t;

  // counter width able to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // a released byte counts as consumed once the strobe was seen and,
  // when asked for, the slave reports grant again
  function automatic logic byte_consumed(input logic strobe_seen,
                                         input logic grant_low,
                                         input bit   need_grant);
    return strobe_seen && (grant_low || !need_grant);
  endfunction

endpackage

// File: rtl/boot_pacer_sync.sv
module boot_pacer_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  // inputs are active-low strobes, so the idle value after reset is 1
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d_async[i];
        s2 <= s1;
      end
    end
    assign q_sync[i] = s2;
  end
endmodule

// File: rtl/boot_pacer_brlatch.sv
module boot_pacer_brlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic bms_n,
  input  logic set_req,
  input  logic clr_req,
  output logic br_n
);
  logic req_q;

  // asynchronous preset from the slave strobe beats any host clear
  always_ff @(posedge clk or negedge rst_n or negedge bms_n) begin
    if (!rst_n)        req_q <= 1'b1;
    else if (!bms_n)   req_q <= 1'b1;
    else if (clr_req)  req_q <= 1'b0;
    else if (set_req)  req_q <= 1'b1;
  end

  assign br_n = ~req_q;
endmodule

// File: rtl/boot_pacer_drive.sv
module boot_pacer_drive #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          release_bus,
  output logic [DW-1:0] data_out,
  output logic          data_oe
);
  logic [DW-1:0] byte_q;
  logic          oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      oe_q   <= 1'b0;
    end else if (release_bus) begin
      oe_q   <= 1'b0;
    end else if (load) begin
      byte_q <= din;
      oe_q   <= 1'b1;
    end
  end

  // gated copy: a released bus shows all zeros beside a low enable
  for (genvar b = 0; b < DW; b++) begin : g_gate
    assign data_out[b] = oe_q & byte_q[b];
  end
  assign data_oe = oe_q;
endmodule

// File: rtl/boot_pacer_ctrl.sv
module boot_pacer_ctrl
  import boot_pacer_pkg::*;
#(
  parameter int WAIT_CYC    = 6,
  parameter int RST_CYC     = 4,
  parameter bit GRANT_CHECK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_start,
  input  logic in_valid,
  input  logic in_last,
  input  logic bms_s,
  input  logic bg_s,
  output logic in_ready,
  output logic load,
  output logic bus_release,
  output logic slave_reset_n,
  output logic latch_set,
  output logic byte_rel,
  output logic fin_rel,
  output logic busy,
  output logic boot_done
);
  localparam int CW = cnt_width(max_of(WAIT_CYC, RST_CYC));

  pace_state_t      state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             last_q, seen_q, bms_prev_q;
  logic             bms_fall, grant_low, consumed, start_ok;

  assign bms_fall = bms_prev_q & ~bms_s;

  if (GRANT_CHECK) begin : g_grant
    assign grant_low = ~bg_s;
  end else begin : g_nogrant
    assign grant_low = 1'b1;
  end

  assign consumed = byte_consumed(seen_q, grant_low, GRANT_CHECK);
  assign start_ok = boot_start && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (boot_start) begin
        state_d = ST_RST_LO;
        cnt_d   = CW'(RST_CYC - 1);
      end
      ST_RST_LO: begin
        if (cnt_q == '0) state_d = ST_GET;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_GET:   if (in_valid) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_REL;
      ST_REL: begin
        state_d = ST_HOLD;
        cnt_d   = CW'(WAIT_CYC - 1);
      end
      ST_HOLD: begin
        if (cnt_q == '0) state_d = ST_GRANT;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_GRANT: if (consumed) state_d = last_q ? ST_FIN : ST_GET;
      ST_FIN:   state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      last_q     <= 1'b0;
      seen_q     <= 1'b0;
      bms_prev_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      bms_prev_q <= bms_s;
      if (state_q == ST_GET && in_valid) last_q <= in_last;
      if (state_q == ST_REL)             seen_q <= 1'b0;
      else if (bms_fall)                 seen_q <= 1'b1;
    end
  end

  assign slave_reset_n = !(state_q == ST_IDLE || state_q == ST_RST_LO);
  assign latch_set     = (state_q == ST_RST_LO);
  assign in_ready      = (state_q == ST_GET);
  assign load          = (state_q == ST_GET) && in_valid;
  assign byte_rel      = (state_q == ST_REL);
  assign fin_rel       = (state_q == ST_FIN);
  assign bus_release   = fin_rel || start_ok;
  assign busy          = !(state_q == ST_IDLE || state_q == ST_DONE);
  assign boot_done     = (state_q == ST_DONE);
endmodule

// File: rtl/boot_pacer.sv
module boot_pacer #(
  parameter int DW          = 8,
  parameter int WAIT_CYC    = 6,
  parameter int RST_CYC     = 4,
  parameter bit GRANT_CHECK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boot_start,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic          slave_reset_n,
  output logic          br_n,
  input  logic          bms_n,
  input  logic          bg_n,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          boot_done
);
  // named internal events, observed by the bound checker
  logic [1:0] strobes_s;
  logic       bms_s, bg_s;
  logic       load, bus_release, latch_set, byte_rel, fin_rel, busy;

  boot_pacer_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({bg_n, bms_n}),
    .q_sync  (strobes_s)
  );
  assign bms_s = strobes_s[0];
  assign bg_s  = strobes_s[1];

  boot_pacer_ctrl #(
    .WAIT_CYC    (WAIT_CYC),
    .RST_CYC     (RST_CYC),
    .GRANT_CHECK (GRANT_CHECK)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .boot_start    (boot_start),
    .in_valid      (in_valid),
    .in_last       (in_last),
    .bms_s         (bms_s),
    .bg_s          (bg_s),
    .in_ready      (in_ready),
    .load          (load),
    .bus_release   (bus_release),
    .slave_reset_n (slave_reset_n),
    .latch_set     (latch_set),
    .byte_rel      (byte_rel),
    .fin_rel       (fin_rel),
    .busy          (busy),
    .boot_done     (boot_done)
  );

  boot_pacer_brlatch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .bms_n   (bms_n),
    .set_req (latch_set),
    .clr_req (byte_rel | fin_rel),
    .br_n    (br_n)
  );

  boot_pacer_drive #(.DW(DW)) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .din         (in_data),
    .release_bus (bus_release),
    .data_out    (data_out),
    .data_oe     (data_oe)
  );
endmodule

// File: rtl/boot_pacer_check.sv
module boot_pacer_check #(
  parameter int DW       = 8,
  parameter int WAIT_CYC = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boot_start,
  input logic          bms_n,
  input logic          br_n,
  input logic          slave_reset_n,
  input logic [DW-1:0] data_out,
  input logic          data_oe,
  input logic          boot_done,
  input logic          in_ready,
  input logic          busy,
  input logic          byte_rel
);
  int since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   since_rel <= WAIT_CYC;
    else if (byte_rel)                            since_rel <= 1;
    else if (since_rel != 0 && since_rel < WAIT_CYC) since_rel <= since_rel + 1;
  end

  AST_RESET_ONLY_WITH_BR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave_reset_n) |-> !br_n);  // R2
  AST_READY_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (slave_reset_n && !boot_done && !br_n));  // R3
  AST_STROBE_PRESETS: assert property (@(posedge clk) disable iff (!rst_n)
    !bms_n |-> !br_n);  // R4
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rel |=> !byte_rel);  // R4
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rel || (since_rel != 0 && since_rel < WAIT_CYC)) |=> $stable(data_out));  // R5
  AST_DONE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (!data_oe && slave_reset_n));  // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slave_reset_n && boot_start) |=> slave_reset_n);  // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !boot_start) |=> boot_done);  // R9
endmodule

bind boot_pacer boot_pacer_check #(.DW(DW), .WAIT_CYC(WAIT_CYC)) u_check (
  .clk           (clk),
  .rst_n         (rst_n),
  .boot_start    (boot_start),
  .bms_n         (bms_n),
  .br_n          (br_n),
  .slave_reset_n (slave_reset_n),
  .data_out      (data_out),
  .data_oe       (data_oe),
  .boot_done     (boot_done),
  .in_ready      (in_ready),
  .busy          (busy),
  .byte_rel      (byte_rel)
);

// File: tb/boot_pacer_test.sv
`timescale 1ns/1ps
module boot_pacer_test;
  localparam int WAIT = 6;
  localparam int NV   = 9;
  // bit 8 = last flag, bits 7:0 = byte; three boots of 3, 5 and 1 bytes
  localparam logic [8:0] VEC [0:NV-1] = '{
    9'h0A5, 9'h03C, 9'h1FF,
    9'h000, 9'h081, 9'h07E, 9'h042, 9'h199,
    9'h15A
  };

  logic clk = 1'b0, rst_n = 1'b0, boot_start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, bms_n = 1'b1, bg_n = 1'b1;
  logic in_ready, slave_reset_n, br_n, data_oe, boot_done;
  logic [7:0] data_out;

  int checks = 0, fails = 0;
  int dly = 2;
  int reads_boot = 0, reads_total = 0, accepted_total = 0, srn_rises = 0;
  logic [7:0] cap [0:31];
  logic [7:0] expv [0:31];
  int exp_n = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  boot_pacer #(.WAIT_CYC(WAIT)) uut (
    .clk(clk), .rst_n(rst_n), .boot_start(boot_start),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .slave_reset_n(slave_reset_n), .br_n(br_n), .bms_n(bms_n), .bg_n(bg_n),
    .data_out(data_out), .data_oe(data_oe), .boot_done(boot_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expd);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expd);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // slave model: one strobe per release, grant follows bus request
  initial forever begin
    @(negedge clk);
    bg_n = br_n;
    if (rst_n && slave_reset_n && br_n && !boot_done) begin
      repeat (dly) @(negedge clk);
      bg_n = br_n;
      bms_n = 1'b0;
      #0.5;
      chk(br_n == 1'b0, "R4 strobe presets br_n", br_n, 0);
      cap[reads_boot & 31] = data_out;
      reads_boot++;
      reads_total++;
      repeat (2) @(negedge clk);
      bms_n = 1'b1;
    end
  end

  // monitors sampled on the falling edge
  initial begin
    logic p_srn, p_br, p_oe;
    logic [7:0] p_data;
    int since;
    p_srn = 0; p_br = 0; p_oe = 0; p_data = 0; since = 0;
    forever begin
      @(negedge clk);
      #0.2;
      if (rst_n) begin
        if (slave_reset_n && !p_srn) begin
          srn_rises++;
          chk(br_n == 1'b0, "R2 br_n low at reset release", br_n, 0);
        end
        if (br_n && !p_br) since = 0; else since++;
        if (data_oe && p_oe && data_out != p_data)
          chk(since >= WAIT, "R5 data held after release", since, WAIT);
        if (in_ready)
          chk(reads_total == accepted_total, "R6 all bytes read before next offer",
              reads_total, accepted_total);
      end
      p_srn = slave_reset_n; p_br = br_n; p_oe = data_oe; p_data = data_out;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 boot_start = 1'b1;
    @(posedge clk); #1 boot_start = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input logic l);
    in_data = b; in_last = l; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    accepted_total++;
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000 && !boot_done; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_boot(input string tag);
    chk(reads_boot == exp_n, "R4 one read per byte", reads_boot, exp_n);
    for (int k = 0; k < exp_n; k++)
      chk(cap[k] == expv[k], "R3 byte order at slave", cap[k], expv[k]);
    chk(boot_done == 1'b1, "R7 boot_done", boot_done, 1);
    chk(data_oe == 1'b0 && data_out == 8'h00, "R7 bus released", {data_oe, data_out}, 0);
    chk(slave_reset_n == 1'b1 && br_n == 1'b1, "R7 slave running", {slave_reset_n, br_n}, 3);
    if (tag.len() == 0) chk(1'b0, "R7 tag", 0, 1);
  endtask

  task automatic check_reset_state();
    chk(slave_reset_n == 0 && br_n == 0 && data_oe == 0 && data_out == 0 &&
        in_ready == 0 && boot_done == 0, "R1 reset state",
        {slave_reset_n, br_n, data_oe, in_ready, boot_done, data_out}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    bit new_boot;
    repeat (3) @(posedge clk);
    #1;
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    // table walk: three boots, a start request ignored mid-boot (R8)
    new_boot = 1;
    for (int i = 0; i < NV; i++) begin
      if (new_boot) begin
        pulse_start();
        reads_boot = 0; exp_n = 0;
        new_boot = 0;
      end
      if (i == 5) pulse_start();  // R8: must not restart
      expv[exp_n] = VEC[i][7:0];
      exp_n++;
      send(VEC[i][7:0], VEC[i][8]);
      if (VEC[i][8]) begin
        wait_done();
        check_boot("table");
        new_boot = 1;
      end
    end
    chk(srn_rises == 3, "R8 slave reset once per boot", srn_rises, 3);

    // R9: done holds without a start
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(boot_done == 1'b1, "R9 done level holds", boot_done, 1);
    end

    // R6: slow slave, grant gate stalls the next offer
    dly = 12;
    pulse_start();
    @(negedge clk);
    chk(slave_reset_n == 0 && boot_done == 0, "R9 restart resets slave",
        {slave_reset_n, boot_done}, 0);
    reads_boot = 0; exp_n = 2;
    expv[0] = 8'h11; expv[1] = 8'h22;
    send(8'h11, 1'b0);
    send(8'h22, 1'b1);
    wait_done();
    check_boot("slow");
    chk(srn_rises == 4, "R2 slow boot single release", srn_rises, 4);
    dly = 2;

    // R1: reset in the middle of a boot
    pulse_start();
    reads_boot = 0;
    send(8'h6C, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check_reset_state();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();
    repeat (4) @(negedge clk);
    chk(slave_reset_n == 0, "R1 stays idle after reset", slave_reset_n, 0);

    summary();
  end
endmodule